// File: doc/BRIEF.md
# JTAG Configuration Access Controller

This block sits behind an IEEE 1149.1 test access port and manages the loading of a device configuration over the scan chain. Its own TAP state machine, instruction register and data registers drive a configuration sequencer. The sequencer tracks whether the device is unconfigured, taking in a bitstream, initialising, running user logic, or held with its I/O under scan control. While the load instruction is active, each bit shifted in on TDI comes back on TDO one TCK later, so a host can check the stream as it goes. A bitstream of exactly the parameterised length, closed by an Update-DR, starts a fixed run of initialisation clocks. When that run ends, the done flag goes high.

The block decides which instruction may take effect, based on the configuration state at the moment of Update-IR. The identification, bypass and sampling instructions are always allowed and never disturb a load. Every other test instruction is silently swapped for bypass while a load or initialisation is under way. Only the I/O-configure instruction can break into a running configuration. Once it has done so, the block stays interrupted until a pulse-configure instruction or a low pulse on the reconfigure pin starts over.

Top module: `jcfg_access_ctrl`

## Requirements
- R1: While the effective instruction is the load instruction (opcode 0x002) and the TAP is in Shift-DR, the bit sampled on `tdi` at a rising TCK edge appears on `tdo` after that edge and stays there until the next edge.
- R2: The state moves from INIT to USER after exactly `INIT_CYCLES` rising TCK edges (default 299), counted from the edge that leaves Update-DR. TAP traffic during that time does not change the count.
- R3: `conf_done` is high only in USER and can only rise directly out of INIT. It is low after any failed or aborted load.
- R4: An Update-DR under the load instruction in LOADING moves to INIT when exactly `CFG_BITS` bits were shifted. Otherwise it moves to UNCONFIGURED.
- R5: BYPASS (0x3FF), IDCODE (0x006) and SAMPLE (0x005) take effect in every state, and loading them during LOADING or INIT leaves the configuration state and the init countdown untouched.
- R6: In LOADING or INIT, EXTEST (0x000) and pulse-configure (0x001) become BYPASS. The load instruction takes effect only in UNCONFIGURED or LOADING and becomes BYPASS elsewhere.
- R7: The I/O-configure instruction (0x00D) takes effect in every state. It moves the state to INTERRUPTED, drops `conf_done` and raises `io_jtag_ctl`.
- R8: INTERRUPTED is left only for UNCONFIGURED, either by pulse-configure or by `reconfig_n` sampled low. A low `reconfig_n` also aborts a load in progress.
- R9: `chip_clr_n` and `chip_oe` have no effect on the TAP, the instruction register or the configuration state.
- R10: The instruction register is 10 bits wide and is shifted LSB first. Capture-IR loads 0b0000000001. Any opcode outside the seven listed decodes as BYPASS.
- R11: Test-Logic-Reset, whether reached through TMS or `trst_n`, selects IDCODE and leaves the configuration state and `conf_done` as they were.
- R12: `cfg_state` reports UNCONFIGURED=0, LOADING=1, INIT=2, USER=3 and INTERRUPTED=4. Reset gives UNCONFIGURED with IDCODE selected.
- R13: Under IDCODE, Capture-DR loads the 32-bit `IDCODE_VAL`, which is then shifted out LSB first. Every other instruction uses a one-bit register that captures 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high power-on reset of the whole block |
| trst_n | input | 1 | Synchronous active-low test reset, forces Test-Logic-Reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| reconfig_n | input | 1 | Active-low reconfigure request, sampled each TCK |
| chip_clr_n | input | 1 | Chip-wide clear for user logic |
| chip_oe | input | 1 | Chip-wide output enable for user I/O |
| tdo | output | 1 | Serial test data out |
| conf_done | output | 1 | Configuration and initialisation complete |
| cfg_state | output | 3 | Current configuration state (debug) |
| ir_active | output | 10 | Effective instruction after legality filtering |
| io_jtag_ctl | output | 1 | I/O buffers under scan control (INTERRUPTED) |
| core_oe | output | 1 | Output enable passed to user I/O in USER |
| core_clr_n | output | 1 | Clear passed to user logic; held low outside USER |

## Verification
The bench builds the block with `CFG_BITS` = 12 so that complete, short (11) and long (13) bitstreams can each be shifted by hand. `INIT_CYCLES` stays at its default of 299, so the edge-exact move into USER is checked at the real length, with IR traffic running inside the countdown. `IDCODE_VAL` is set to a pattern with mixed bits, so a shift-order or capture fault shows up in the 32-bit readback. A table of instruction loads takes the state from UNCONFIGURED through LOADING and INTERRUPTED and back, checking which opcodes the filter lets through in each state.

// File: rtl/jcfg_pkg.sv
package jcfg_pkg;

    localparam int IR_W = 10;
    localparam int ID_W = 32;
    localparam logic [IR_W-1:0] IR_CAPTURE = 10'b00_0000_0001;

    typedef enum logic [3:0] {
        TAP_TLR      = 4'h0,
        TAP_RTI      = 4'h1,
        TAP_SEL_DR   = 4'h2,
        TAP_CAP_DR   = 4'h3,
        TAP_SH_DR    = 4'h4,
        TAP_EX1_DR   = 4'h5,
        TAP_PAUSE_DR = 4'h6,
        TAP_EX2_DR   = 4'h7,
        TAP_UPD_DR   = 4'h8,
        TAP_SEL_IR   = 4'h9,
        TAP_CAP_IR   = 4'hA,
        TAP_SH_IR    = 4'hB,
        TAP_EX1_IR   = 4'hC,
        TAP_PAUSE_IR = 4'hD,
        TAP_EX2_IR   = 4'hE,
        TAP_UPD_IR   = 4'hF
    } tap_state_t;

    typedef enum logic [2:0] {
        CFG_UNCONF      = 3'd0,
        CFG_LOADING     = 3'd1,
        CFG_INIT        = 3'd2,
        CFG_USER        = 3'd3,
        CFG_INTERRUPTED = 3'd4
    } cfg_state_t;

    typedef enum logic [IR_W-1:0] {
        OP_EXTEST = 10'h000,
        OP_PULSE  = 10'h001,
        OP_LOAD   = 10'h002,
        OP_SAMPLE = 10'h005,
        OP_IDCODE = 10'h006,
        OP_IOCFG  = 10'h00D,
        OP_BYPASS = 10'h3FF
    } op_t;

    function automatic tap_state_t tap_next(tap_state_t s, logic tms);
        case (s)
            TAP_TLR:      return tms ? TAP_TLR    : TAP_RTI;
            TAP_RTI:      return tms ? TAP_SEL_DR : TAP_RTI;
            TAP_SEL_DR:   return tms ? TAP_SEL_IR : TAP_CAP_DR;
            TAP_CAP_DR:   return tms ? TAP_EX1_DR : TAP_SH_DR;
            TAP_SH_DR:    return tms ? TAP_EX1_DR : TAP_SH_DR;
            TAP_EX1_DR:   return tms ? TAP_UPD_DR : TAP_PAUSE_DR;
            TAP_PAUSE_DR: return tms ? TAP_EX2_DR : TAP_PAUSE_DR;
            TAP_EX2_DR:   return tms ? TAP_UPD_DR : TAP_SH_DR;
            TAP_UPD_DR:   return tms ? TAP_SEL_DR : TAP_RTI;
            TAP_SEL_IR:   return tms ? TAP_TLR    : TAP_CAP_IR;
            TAP_CAP_IR:   return tms ? TAP_EX1_IR : TAP_SH_IR;
            TAP_SH_IR:    return tms ? TAP_EX1_IR : TAP_SH_IR;
            TAP_EX1_IR:   return tms ? TAP_UPD_IR : TAP_PAUSE_IR;
            TAP_PAUSE_IR: return tms ? TAP_EX2_IR : TAP_PAUSE_IR;
            TAP_EX2_IR:   return tms ? TAP_UPD_IR : TAP_SH_IR;
            default:      return tms ? TAP_SEL_DR : TAP_RTI;
        endcase
    endfunction

    function automatic logic tap_ir_side(tap_state_t s);
        return (s == TAP_CAP_IR) || (s == TAP_SH_IR) || (s == TAP_EX1_IR) ||
               (s == TAP_PAUSE_IR) || (s == TAP_EX2_IR) || (s == TAP_UPD_IR);
    endfunction

    function automatic op_t op_decode(logic [IR_W-1:0] raw);
        case (raw)
            10'h000: return OP_EXTEST;
            10'h001: return OP_PULSE;
            10'h002: return OP_LOAD;
            10'h005: return OP_SAMPLE;
            10'h006: return OP_IDCODE;
            10'h00D: return OP_IOCFG;
            default: return OP_BYPASS;
        endcase
    endfunction

    function automatic logic cfg_busy(cfg_state_t s);
        return (s == CFG_LOADING) || (s == CFG_INIT);
    endfunction

    function automatic op_t op_filter(op_t op, cfg_state_t s);
        case (op)
            OP_BYPASS, OP_IDCODE, OP_SAMPLE, OP_IOCFG: return op;
            OP_LOAD:
                return ((s == CFG_UNCONF) || (s == CFG_LOADING)) ? op : OP_BYPASS;
            default:
                return cfg_busy(s) ? OP_BYPASS : op;
        endcase
    endfunction

endpackage

// File: rtl/jcfg_tap.sv
module jcfg_tap
    import jcfg_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t tap_st
);

    always_ff @(posedge tck) begin
        if (rst || !trst_n) begin
            tap_st <= TAP_TLR;
        end else begin
            tap_st <= tap_next(tap_st, tms);
        end
    end

endmodule

// File: rtl/jcfg_ir.sv
module jcfg_ir
    import jcfg_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  tap_state_t tap_st,
    input  logic       tdi,
    input  cfg_state_t cfg_st,
    output op_t        ir_eff,
    output op_t        ir_new,
    output logic       ir_lsb
);

    logic [IR_W-1:0] ir_sr;

    // legality is judged against the state at the moment of Update-IR
    assign ir_new = op_filter(op_decode(ir_sr), cfg_st);
    assign ir_lsb = ir_sr[0];

    always_ff @(posedge tck) begin
        if (rst) begin
            ir_sr  <= '0;
            ir_eff <= OP_IDCODE;
        end else begin
            case (tap_st)
                TAP_CAP_IR: ir_sr <= IR_CAPTURE;
                TAP_SH_IR:  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                default:    ;
            endcase
            if (tap_st == TAP_TLR) begin
                ir_eff <= OP_IDCODE;
            end else if (tap_st == TAP_UPD_IR) begin
                ir_eff <= ir_new;
            end
        end
    end

endmodule

// File: rtl/jcfg_dr.sv
module jcfg_dr
    import jcfg_pkg::*;
#(
    parameter logic [ID_W-1:0] IDCODE_VAL = 32'h0A5C_30DD
) (
    input  logic       tck,
    input  logic       rst,
    input  tap_state_t tap_st,
    input  logic       tdi,
    input  op_t        ir_eff,
    input  logic       ir_lsb,
    output logic       tdo
);

    logic [ID_W-1:0] id_sr;
    logic            one_bit;   // bypass, sample stand-in and config echo stage

    always_ff @(posedge tck) begin
        if (rst) begin
            id_sr   <= '0;
            one_bit <= 1'b0;
        end else begin
            case (tap_st)
                TAP_CAP_DR: begin
                    id_sr   <= IDCODE_VAL;
                    one_bit <= 1'b0;
                end
                TAP_SH_DR: begin
                    if (ir_eff == OP_IDCODE) begin
                        id_sr <= {tdi, id_sr[ID_W-1:1]};
                    end else begin
                        one_bit <= tdi;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        if (tap_ir_side(tap_st)) begin
            tdo = ir_lsb;
        end else if (ir_eff == OP_IDCODE) begin
            tdo = id_sr[0];
        end else begin
            tdo = one_bit;
        end
    end

endmodule

// File: rtl/jcfg_seq.sv
module jcfg_seq
    import jcfg_pkg::*;
#(
    parameter int CFG_BITS    = 1024,
    parameter int INIT_CYCLES = 299
) (
    input  logic       tck,
    input  logic       rst,
    input  logic       reconfig_n,
    input  tap_state_t tap_st,
    input  op_t        ir_eff,
    input  op_t        ir_new,
    output cfg_state_t cfg_st
);

    localparam int BCW = $clog2(CFG_BITS + 2);
    localparam int ICW = $clog2(INIT_CYCLES + 1);
    localparam logic [BCW-1:0] BITS_FULL = BCW'(CFG_BITS);
    localparam logic [BCW-1:0] BITS_OVER = BCW'(CFG_BITS + 1);
    localparam logic [ICW-1:0] INIT_LAST = ICW'(INIT_CYCLES - 1);

    logic [BCW-1:0] bit_cnt;
    logic [ICW-1:0] init_cnt;
    logic           ir_upd;
    logic           shift_cfg;
    logic           upd_cfg;

    assign ir_upd    = (tap_st == TAP_UPD_IR);
    assign shift_cfg = (tap_st == TAP_SH_DR)  && (ir_eff == OP_LOAD);
    assign upd_cfg   = (tap_st == TAP_UPD_DR) && (ir_eff == OP_LOAD);

    always_ff @(posedge tck) begin
        if (rst) begin
            cfg_st   <= CFG_UNCONF;
            bit_cnt  <= '0;
            init_cnt <= '0;
        end else if (!reconfig_n) begin
            cfg_st   <= CFG_UNCONF;
            bit_cnt  <= '0;
            init_cnt <= '0;
        end else if (ir_upd && (ir_new == OP_IOCFG)) begin
            cfg_st  <= CFG_INTERRUPTED;
            bit_cnt <= '0;
        end else if (ir_upd && (ir_new == OP_PULSE)) begin
            cfg_st  <= CFG_UNCONF;
            bit_cnt <= '0;
        end else begin
            case (cfg_st)
                CFG_UNCONF: begin
                    if (ir_upd && (ir_new == OP_LOAD)) begin
                        cfg_st  <= CFG_LOADING;
                        bit_cnt <= '0;
                    end
                end
                CFG_LOADING: begin
                    if (tap_st == TAP_TLR) begin
                        bit_cnt <= '0;
                    end else if (shift_cfg) begin
                        if (bit_cnt != BITS_OVER) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end else if (upd_cfg) begin
                        cfg_st   <= (bit_cnt == BITS_FULL) ? CFG_INIT : CFG_UNCONF;
                        bit_cnt  <= '0;
                        init_cnt <= '0;
                    end
                end
                CFG_INIT: begin
                    if (init_cnt == INIT_LAST) begin
                        cfg_st <= CFG_USER;
                    end else begin
                        init_cnt <= init_cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/jcfg_access_ctrl.sv
module jcfg_access_ctrl
    import jcfg_pkg::*;
#(
    parameter int               CFG_BITS    = 1024,
    parameter int               INIT_CYCLES = 299,
    parameter logic [ID_W-1:0]  IDCODE_VAL  = 32'h0A5C_30DD
) (
    input  logic            tck,
    input  logic            rst,
    input  logic            trst_n,
    input  logic            tms,
    input  logic            tdi,
    input  logic            reconfig_n,
    input  logic            chip_clr_n,
    input  logic            chip_oe,
    output logic            tdo,
    output logic            conf_done,
    output logic [2:0]      cfg_state,
    output logic [IR_W-1:0] ir_active,
    output logic            io_jtag_ctl,
    output logic            core_oe,
    output logic            core_clr_n
);

    tap_state_t tap_st;
    cfg_state_t cfg_st;
    op_t        ir_eff_q;
    op_t        ir_new;
    logic       ir_lsb;
    logic       in_user;

    jcfg_tap u_tap (
        .tck    (tck),
        .rst    (rst),
        .trst_n (trst_n),
        .tms    (tms),
        .tap_st (tap_st)
    );

    jcfg_ir u_ir (
        .tck    (tck),
        .rst    (rst),
        .tap_st (tap_st),
        .tdi    (tdi),
        .cfg_st (cfg_st),
        .ir_eff (ir_eff_q),
        .ir_new (ir_new),
        .ir_lsb (ir_lsb)
    );

    jcfg_dr #(
        .IDCODE_VAL (IDCODE_VAL)
    ) u_dr (
        .tck    (tck),
        .rst    (rst),
        .tap_st (tap_st),
        .tdi    (tdi),
        .ir_eff (ir_eff_q),
        .ir_lsb (ir_lsb),
        .tdo    (tdo)
    );

    jcfg_seq #(
        .CFG_BITS    (CFG_BITS),
        .INIT_CYCLES (INIT_CYCLES)
    ) u_seq (
        .tck        (tck),
        .rst        (rst),
        .reconfig_n (reconfig_n),
        .tap_st     (tap_st),
        .ir_eff     (ir_eff_q),
        .ir_new     (ir_new),
        .cfg_st     (cfg_st)
    );

    // chip-wide pins reach only the user side, never the scan or config path
    assign in_user     = (cfg_st == CFG_USER);
    assign conf_done   = in_user;
    assign cfg_state   = cfg_st;
    assign ir_active   = ir_eff_q;
    assign io_jtag_ctl = (cfg_st == CFG_INTERRUPTED);
    assign core_oe     = in_user && chip_oe;
    assign core_clr_n  = in_user && chip_clr_n;

endmodule

// File: rtl/jcfg_access_ctrl_chk.sv
module jcfg_access_ctrl_chk
    import jcfg_pkg::*;
#(
    parameter int INIT_CYCLES = 299
) (
    input logic       tck,
    input logic       rst,
    input logic       tdi,
    input logic       tdo,
    input tap_state_t tap_st,
    input cfg_state_t cfg_st,
    input op_t        ir_eff,
    input logic       conf_done
);

    int unsigned init_run;

    always_ff @(posedge tck) begin
        if (rst) begin
            init_run <= 0;
        end else if (cfg_st == CFG_INIT) begin
            init_run <= init_run + 1;
        end else begin
            init_run <= 0;
        end
    end

    AST_CFG_ECHO: assert property (@(posedge tck) disable iff (rst)
        (tap_st == TAP_SH_DR && ir_eff == OP_LOAD) |=> (tdo == $past(tdi))); // R1

    AST_INIT_LENGTH: assert property (@(posedge tck) disable iff (rst)
        (cfg_st == CFG_USER && $past(cfg_st) == CFG_INIT) |-> (init_run == INIT_CYCLES)); // R2

    AST_DONE_FROM_INIT: assert property (@(posedge tck) disable iff (rst)
        $rose(conf_done) |-> ($past(cfg_st) == CFG_INIT)); // R3

    AST_BUSY_FILTER: assert property (@(posedge tck) disable iff (rst)
        (cfg_st == CFG_LOADING || cfg_st == CFG_INIT) |->
            (ir_eff inside {OP_BYPASS, OP_IDCODE, OP_SAMPLE, OP_LOAD})); // R6

    AST_INTERRUPT_EXIT: assert property (@(posedge tck) disable iff (rst)
        (cfg_st == CFG_INTERRUPTED) |=> (cfg_st inside {CFG_INTERRUPTED, CFG_UNCONF})); // R8

    AST_TLR_IDCODE: assert property (@(posedge tck) disable iff (rst)
        (tap_st == TAP_TLR) |=> (ir_eff == OP_IDCODE)); // R11

endmodule

bind jcfg_access_ctrl jcfg_access_ctrl_chk #(
    .INIT_CYCLES (INIT_CYCLES)
) u_chk (
    .tck       (tck),
    .rst       (rst),
    .tdi       (tdi),
    .tdo       (tdo),
    .tap_st    (tap_st),
    .cfg_st    (cfg_st),
    .ir_eff    (ir_eff_q),
    .conf_done (conf_done)
);

// File: tb/jcfg_access_ctrl_test.sv
module jcfg_access_ctrl_test;

    localparam int          CLK_PERIOD = 10;
    localparam int          T_BITS     = 12;
    localparam int          T_INIT     = 299;
    localparam logic [31:0] T_ID       = 32'h9E37_4C2B;
    localparam logic [31:0] PAT        = 32'hB5C3_9A6E;

    localparam logic [9:0] C_EXTEST = 10'h000;
    localparam logic [9:0] C_PULSE  = 10'h001;
    localparam logic [9:0] C_LOAD   = 10'h002;
    localparam logic [9:0] C_SAMPLE = 10'h005;
    localparam logic [9:0] C_IDCODE = 10'h006;
    localparam logic [9:0] C_IOCFG  = 10'h00D;
    localparam logic [9:0] C_BYPASS = 10'h3FF;

    // {opcode shifted, effective opcode expected, state expected}: R5 R6 R7 R8 R10
    localparam logic [22:0] TBL [12] = '{
        {10'h000, 10'h000, 3'd0},
        {10'h002, 10'h002, 3'd1},
        {10'h000, 10'h3FF, 3'd1},
        {10'h005, 10'h005, 3'd1},
        {10'h006, 10'h006, 3'd1},
        {10'h001, 10'h3FF, 3'd1},
        {10'h155, 10'h3FF, 3'd1},
        {10'h002, 10'h002, 3'd1},
        {10'h00D, 10'h00D, 3'd4},
        {10'h002, 10'h3FF, 3'd4},
        {10'h000, 10'h000, 3'd4},
        {10'h001, 10'h001, 3'd0}
    };

    logic       tck = 1'b0;
    logic       rst, trst_n, tms, tdi, reconfig_n, chip_clr_n, chip_oe;
    logic       tdo, conf_done, io_jtag_ctl, core_oe, core_clr_n;
    logic [2:0] cfg_state;
    logic [9:0] ir_active;

    int checks = 0;
    int errors = 0;

    jcfg_access_ctrl #(
        .CFG_BITS    (T_BITS),
        .INIT_CYCLES (T_INIT),
        .IDCODE_VAL  (T_ID)
    ) uut (
        .tck         (tck),
        .rst         (rst),
        .trst_n      (trst_n),
        .tms         (tms),
        .tdi         (tdi),
        .reconfig_n  (reconfig_n),
        .chip_clr_n  (chip_clr_n),
        .chip_oe     (chip_oe),
        .tdo         (tdo),
        .conf_done   (conf_done),
        .cfg_state   (cfg_state),
        .ir_active   (ir_active),
        .io_jtag_ctl (io_jtag_ctl),
        .core_oe     (core_oe),
        .core_clr_n  (core_clr_n)
    );

    always #(CLK_PERIOD / 2) tck = ~tck;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0);
    endtask

    // from Run-Test/Idle, shift an opcode, update, back to Run-Test/Idle
    task automatic load_ir(input logic [9:0] op);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < 10; i++) step(i == 9, op[i]);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    // from Run-Test/Idle, shift n bits through the DR with echo checks, update, idle
    task automatic shift_dr(input int n, input logic wiggle);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        for (int i = 0; i < n; i++) begin
            logic b;
            b = PAT[i % 32];
            if (wiggle) begin
                chip_clr_n = ~chip_clr_n;
                chip_oe    = ~chip_oe;
            end
            step(i == n - 1, b);
            check({31'd0, tdo}, {31'd0, b}, "R1 echo one TCK later");
        end
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
    endtask

    initial begin
        repeat (60000) @(posedge tck);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; trst_n = 1'b1; tms = 1'b1; tdi = 1'b0;
        reconfig_n = 1'b1; chip_clr_n = 1'b1; chip_oe = 1'b0;
        repeat (3) @(posedge tck);
        @(negedge tck);
        rst = 1'b0;

        // R12 reset state
        check({29'd0, cfg_state}, 32'd0, "R12 reset state");
        check({31'd0, conf_done}, 32'd0, "R3 done low after reset");
        check({22'd0, ir_active}, {22'd0, C_IDCODE}, "R12 IDCODE after reset");
        step(1'b0, 1'b0);

        // R6 R10 R7 R8 R5 legality walk
        for (int k = 0; k < 12; k++) begin
            load_ir(TBL[k][22:13]);
            check({22'd0, ir_active}, {22'd0, TBL[k][12:3]}, "R6 R10 effective opcode");
            check({29'd0, cfg_state}, {29'd0, TBL[k][2:0]}, "R8 state after IR load");
        end

        // full load, chip-wide pins toggling throughout (R9, R4)
        load_ir(C_LOAD);
        check({29'd0, cfg_state}, 32'd1, "R12 LOADING");
        shift_dr(T_BITS, 1'b1);
        chip_clr_n = 1'b1; chip_oe = 1'b0;
        check({29'd0, cfg_state}, 32'd2, "R4 full length enters INIT");
        check({31'd0, conf_done}, 32'd0, "R3 done low in INIT");
        // R5 and R6 traffic during the countdown
        load_ir(C_IDCODE);
        check({22'd0, ir_active}, {22'd0, C_IDCODE}, "R5 IDCODE in INIT");
        check({29'd0, cfg_state}, 32'd2, "R5 INIT undisturbed");
        load_ir(C_EXTEST);
        check({22'd0, ir_active}, {22'd0, C_BYPASS}, "R6 EXTEST blocked in INIT");
        idle(T_INIT - 1 - 32);
        check({29'd0, cfg_state}, 32'd2, "R2 still INIT one edge early");
        check({31'd0, conf_done}, 32'd0, "R2 done low one edge early");
        idle(1);
        check({29'd0, cfg_state}, 32'd3, "R2 USER after 299 edges");
        check({31'd0, conf_done}, 32'd1, "R3 done high in USER");

        // R13 IDCODE readback
        begin
            logic [31:0] word;
            load_ir(C_IDCODE);
            step(1'b1, 1'b0);
            step(1'b0, 1'b0);
            step(1'b0, 1'b0);
            for (int i = 0; i < 32; i++) begin
                word[i] = tdo;
                step(i == 31, 1'b0);
            end
            step(1'b1, 1'b0);
            step(1'b0, 1'b0);
            check(word, T_ID, "R13 IDCODE readback");
        end

        // R11 Test-Logic-Reset via TMS and via trst_n
        load_ir(C_BYPASS);
        repeat (5) step(1'b1, 1'b0);
        check({22'd0, ir_active}, {22'd0, C_IDCODE}, "R11 TLR selects IDCODE");
        check({29'd0, cfg_state}, 32'd3, "R11 TLR keeps USER");
        step(1'b0, 1'b0);
        load_ir(C_SAMPLE);
        trst_n = 1'b0;
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        trst_n = 1'b1;
        step(1'b0, 1'b0);
        check({22'd0, ir_active}, {22'd0, C_IDCODE}, "R11 trst selects IDCODE");
        check({31'd0, conf_done}, 32'd1, "R11 trst keeps done");

        // R7 interrupt from USER, R8 exit by reconfig_n
        load_ir(C_IOCFG);
        check({29'd0, cfg_state}, 32'd4, "R7 INTERRUPTED from USER");
        check({31'd0, conf_done}, 32'd0, "R7 done dropped");
        check({31'd0, io_jtag_ctl}, 32'd1, "R7 I/O under scan control");
        idle(3);
        check({29'd0, cfg_state}, 32'd4, "R8 INTERRUPTED holds");
        reconfig_n = 1'b0;
        step(1'b0, 1'b0);
        reconfig_n = 1'b1;
        check({29'd0, cfg_state}, 32'd0, "R8 reconfig_n exits INTERRUPTED");

        // R4 short and long bitstreams
        load_ir(C_LOAD);
        shift_dr(T_BITS - 1, 1'b0);
        check({29'd0, cfg_state}, 32'd0, "R4 short load fails");
        check({31'd0, conf_done}, 32'd0, "R3 done low after short load");
        load_ir(C_LOAD);
        shift_dr(T_BITS + 1, 1'b0);
        check({29'd0, cfg_state}, 32'd0, "R4 long load fails");

        // R8 reconfig_n aborts a load in progress
        load_ir(C_LOAD);
        reconfig_n = 1'b0;
        step(1'b0, 1'b0);
        reconfig_n = 1'b1;
        check({29'd0, cfg_state}, 32'd0, "R8 reconfig_n aborts LOADING");

        // R9 chip-wide pins held active leave scan and state alone
        chip_clr_n = 1'b0;
        chip_oe    = 1'b1;
        load_ir(C_EXTEST);
        check({22'd0, ir_active}, {22'd0, C_EXTEST}, "R9 IR loads with chip pins active");
        check({29'd0, cfg_state}, 32'd0, "R9 state unchanged by chip pins");
        check({31'd0, core_oe}, 32'd0, "R9 no output enable outside USER");
        chip_clr_n = 1'b1;
        chip_oe    = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule